// File: doc/BRIEF.md
# Poisoned Packet Error Status Tracker

This block sits beside the transaction layer of a PCI Express endpoint. It looks at the first header dword of every packet that arrives from the link or leaves for it. It keeps the two parity-related error bits of the configuration status word up to date. Each header is classified by its format/type byte and by its error/poisoned flag. A corrupted packet is never dropped. Received packets go on to the application one cycle later with the flag unchanged, and packets the application submits go on to the link one cycle later, also unchanged.

A small bank of configuration words stands in for configuration storage. Word 0 holds the command half in bits 15:0 and the status half in bits 31:16. Configuration reads are answered with a completion that this block builds itself. Configuration writes update the bank, except when the write is itself marked as corrupted. Software clears a status bit by writing a 1 to its position in word 0.

Top module: `poison_status_tracker`

## Requirements
- R1: After a synchronous active-low reset, both status bits, the command word and every stored word are 0. The outputs app_valid, link_valid and cpl_valid are 0.
- R2: A received header with valid high and bit 14 (the poisoned flag) at 1 sets the detected-error bit (status bit 15, word 0 bit 31) on the next cycle. This happens whatever the command word holds and whatever the packet type.
- R3: When command bit 6 (error-report enable) is 1, a transmitted header with type byte (bits 31:24) 0x40 or 0x60 and bit 14 at 1 sets the master-error bit (status bit 8, word 0 bit 24) on the next cycle.
- R4: When command bit 6 is 1, a received header with type byte 0x4A and bit 14 at 1 sets the master-error bit on the next cycle.
- R5: While command bit 6 is 0, no event sets the master-error bit. A transmitted poisoned packet never sets the detected-error bit.
- R6: A received configuration write has type byte 0x44, bit 14 at 0 and rx_cfg_idx set to 0. Data bit 31 at 1 clears the detected-error bit and data bit 24 at 1 clears the master-error bit. A 0 in either position leaves that bit as it is. Data bits 15:0 become the command word.
- R7: If a set condition and a software clear reach the same status bit in the same cycle, the bit ends up at 1.
- R8: A received configuration write with bit 14 at 1 changes no stored word, no command bit and no status bit through its data. It still sets the detected-error bit as in R2.
- R9: Each received header appears on app_hdr0 and app_data one cycle later, with app_valid high and app_poisoned equal to its bit 14.
- R10: Each transmitted header appears on link_hdr0 one cycle later with link_valid high, poisoned or not.
- R11: A received configuration read has type byte 0x04. One cycle later it produces cpl_valid together with cpl_hdr0 = 0x4A000001, so bit 14 is always 0. It also returns cpl_data, the addressed word as it stood before that cycle.
- R12: A receive event and a transmit event in the same cycle are both recorded in the status bits and both forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive header strobe |
| rx_hdr0 | input | 32 | Receive header dword 0 |
| rx_cfg_idx | input | IDX_W | Configuration word index for a configuration request |
| rx_data | input | 32 | Receive payload dword |
| tx_valid | input | 1 | Transmit header strobe |
| tx_hdr0 | input | 32 | Transmit header dword 0 |
| app_valid | output | 1 | Forwarded receive strobe |
| app_hdr0 | output | 32 | Forwarded receive header |
| app_data | output | 32 | Forwarded receive payload |
| app_poisoned | output | 1 | Poisoned flag of the forwarded packet |
| link_valid | output | 1 | Forwarded transmit strobe |
| link_hdr0 | output | 32 | Forwarded transmit header |
| cpl_valid | output | 1 | Configuration completion strobe |
| cpl_hdr0 | output | 32 | Completion header dword 0 |
| cpl_data | output | 32 | Completion payload |
| detected_perr | output | 1 | Status bit 15 |
| master_perr | output | 1 | Status bit 8 |

## Verification
The bench goes after the cycle in which a status set and a software clear land on the same bit. A design that gives priority to the clear would lose the error there. It sends a corrupted configuration write that would have disabled reporting and overwritten a stored word. A design that let this write through would read back changed contents. It also raises the master-error conditions while reporting is disabled, which a missing enable gate would turn into a set bit. Finally it drives a receive and a transmit event in the same cycle, which catches a design that serves only one direction.

// File: rtl/pstat_pkg.sv
// Package: shared constants and types for the poisoned-packet status tracker.
// Assumes header dword 0 carries the format/type byte in bits 31:24.
package pstat_pkg;
    localparam int HDR_W    = 32;
    localparam int EP_BIT   = 14;
    localparam int FT_MSB   = 31;
    localparam int FT_LSB   = 24;
    localparam int FT_W     = FT_MSB - FT_LSB + 1;

    localparam logic [FT_W-1:0] FT_MWR32  = 8'h40;
    localparam logic [FT_W-1:0] FT_MWR64  = 8'h60;
    localparam logic [FT_W-1:0] FT_CFGWR0 = 8'h44;
    localparam logic [FT_W-1:0] FT_CFGRD0 = 8'h04;
    localparam logic [FT_W-1:0] FT_CPLD   = 8'h4A;

    // positions inside configuration word 0
    localparam int CMD_W       = 16;
    localparam int CMD_RPT_EN  = 6;
    localparam int WORD_DPE    = 31;
    localparam int WORD_MDPE   = 24;

    // header of a completion built locally: error flag cleared, length 1
    localparam logic [HDR_W-1:0] LOCAL_CPL_HDR = 32'h4A00_0001;

    typedef struct packed {
        logic mem_wr;
        logic cfg_wr;
        logic cfg_rd;
        logic cpld;
        logic poisoned;
    } hdr_class_t;
endpackage

// File: rtl/tlp_hdr_class.sv
// Module: classifies one header by its type byte and error flag.
// Assumes: purely combinational; every output is qualified by the strobe.
module tlp_hdr_class
    import pstat_pkg::*;
(
    input  logic            valid,
    input  logic [FT_W-1:0] fmt_type,
    input  logic            ep,
    output hdr_class_t      cls
);
    // decode the type byte into class flags
    always_comb begin
        cls.mem_wr   = valid && (fmt_type == FT_MWR32 || fmt_type == FT_MWR64);
        cls.cfg_wr   = valid && (fmt_type == FT_CFGWR0);
        cls.cfg_rd   = valid && (fmt_type == FT_CFGRD0);
        cls.cpld     = valid && (fmt_type == FT_CPLD);
        cls.poisoned = valid && ep;
    end
endmodule

// File: rtl/perr_status_bits.sv
// Module: holds the two error status bits with set-over-clear priority.
// Assumes: set and clear pulses last one cycle; synchronous active-low reset.
module perr_status_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic set_dpe,
    input  logic set_mdpe,
    input  logic clr_dpe,
    input  logic clr_mdpe,
    output logic dpe,
    output logic mdpe
);
    // update both bits; a set in the same cycle beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpe  <= 1'b0;
            mdpe <= 1'b0;
        end else begin
            dpe  <= set_dpe  | (dpe  & ~clr_dpe);
            mdpe <= set_mdpe | (mdpe & ~clr_mdpe);
        end
    end
endmodule

// File: rtl/cfg_shadow_regs.sv
// Module: small configuration word bank. Word 0 = {status, command};
// words 1..NREGS-1 are plain storage. Writes to word 0 produce one-cycle clear
// requests for the status bits (write 1 to clear).
// Assumes: wr_en already excludes corrupted writes; reads see pre-write state.
module cfg_shadow_regs
    import pstat_pkg::*;
#(
    parameter  int NREGS = 4,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [HDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             dpe,
    input  logic             mdpe,
    output logic [CMD_W-1:0] cmd,
    output logic [HDR_W-1:0] rd_data,
    output logic             clr_dpe,
    output logic             clr_mdpe
);
    logic [HDR_W-1:0] words [1:NREGS-1];
    logic             wr_word0;

    // detect a write that targets word 0
    always_comb wr_word0 = wr_en && (wr_idx == '0);

    // clear requests for the status bits
    always_comb begin
        clr_dpe  = wr_word0 && wr_data[WORD_DPE];
        clr_mdpe = wr_word0 && wr_data[WORD_MDPE];
    end

    // command half of word 0
    always_ff @(posedge clk) begin
        if (!rst_n)        cmd <= '0;
        else if (wr_word0) cmd <= wr_data[CMD_W-1:0];
    end

    // plain storage words, one register per index
    for (genvar g = 1; g < NREGS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                words[g] <= wr_data;
        end
    end

    // read mux: word 0 assembles status and command
    always_comb begin
        if (rd_idx == '0)
            rd_data = {dpe, 6'b0, mdpe, 8'b0, cmd};
        else
            rd_data = words[rd_idx];
    end
endmodule

// File: rtl/poison_status_tracker.sv
// Module: top of the poisoned-packet status tracker. Classifies receive and
// transmit headers, maintains the two error status bits, blocks corrupted
// configuration writes, answers configuration reads with clean completions,
// and forwards both directions one cycle later without dropping anything.
// Assumes: one header per direction per cycle; synchronous active-low reset.
module poison_status_tracker
    import pstat_pkg::*;
#(
    parameter  int NREGS = 4,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [31:0]      rx_hdr0,
    input  logic [IDX_W-1:0] rx_cfg_idx,
    input  logic [31:0]      rx_data,
    input  logic             tx_valid,
    input  logic [31:0]      tx_hdr0,
    output logic             app_valid,
    output logic [31:0]      app_hdr0,
    output logic [31:0]      app_data,
    output logic             app_poisoned,
    output logic             link_valid,
    output logic [31:0]      link_hdr0,
    output logic             cpl_valid,
    output logic [31:0]      cpl_hdr0,
    output logic [31:0]      cpl_data,
    output logic             detected_perr,
    output logic             master_perr
);
    localparam int DIRS   = 2;
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    logic       [DIRS-1:0]           dir_valid;
    logic       [DIRS-1:0][HDR_W-1:0] dir_hdr;
    hdr_class_t                      dir_cls [DIRS];
    hdr_class_t                      rx_cls, tx_cls;

    logic [CMD_W-1:0] cmd_q;
    logic [HDR_W-1:0] rd_data;
    logic             perr_en;
    logic             set_dpe, set_mdpe, clr_dpe, clr_mdpe, cfg_wr_en;

    // gather both directions for the shared decoder structure
    always_comb begin
        dir_valid[DIR_RX] = rx_valid;
        dir_valid[DIR_TX] = tx_valid;
        dir_hdr[DIR_RX]   = rx_hdr0;
        dir_hdr[DIR_TX]   = tx_hdr0;
    end

    for (genvar d = 0; d < DIRS; d++) begin : g_dec
        tlp_hdr_class u_cls (
            .valid    (dir_valid[d]),
            .fmt_type (dir_hdr[d][FT_MSB:FT_LSB]),
            .ep       (dir_hdr[d][EP_BIT]),
            .cls      (dir_cls[d])
        );
    end

    // name the two decoded results
    always_comb begin
        rx_cls = dir_cls[DIR_RX];
        tx_cls = dir_cls[DIR_TX];
    end

    // status set conditions and configuration write gating
    always_comb begin
        perr_en   = cmd_q[CMD_RPT_EN];
        set_dpe   = rx_cls.poisoned;
        set_mdpe  = perr_en && ((tx_cls.mem_wr && tx_cls.poisoned) ||
                                (rx_cls.cpld   && rx_cls.poisoned));
        cfg_wr_en = rx_cls.cfg_wr && !rx_cls.poisoned;
    end

    cfg_shadow_regs #(.NREGS(NREGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_idx   (rx_cfg_idx),
        .wr_data  (rx_data),
        .rd_idx   (rx_cfg_idx),
        .dpe      (detected_perr),
        .mdpe     (master_perr),
        .cmd      (cmd_q),
        .rd_data  (rd_data),
        .clr_dpe  (clr_dpe),
        .clr_mdpe (clr_mdpe)
    );

    perr_status_bits u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_dpe  (set_dpe),
        .set_mdpe (set_mdpe),
        .clr_dpe  (clr_dpe),
        .clr_mdpe (clr_mdpe),
        .dpe      (detected_perr),
        .mdpe     (master_perr)
    );

    // forward receive packets to the application, flag intact
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_valid    <= 1'b0;
            app_hdr0     <= '0;
            app_data     <= '0;
            app_poisoned <= 1'b0;
        end else begin
            app_valid    <= rx_valid;
            app_hdr0     <= rx_hdr0;
            app_data     <= rx_data;
            app_poisoned <= rx_cls.poisoned;
        end
    end

    // forward transmit packets to the link without blocking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_hdr0  <= '0;
        end else begin
            link_valid <= tx_valid;
            link_hdr0  <= tx_hdr0;
        end
    end

    // answer configuration reads with a locally built clean completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid <= 1'b0;
            cpl_hdr0  <= '0;
            cpl_data  <= '0;
        end else begin
            cpl_valid <= rx_cls.cfg_rd;
            cpl_hdr0  <= rx_cls.cfg_rd ? LOCAL_CPL_HDR : '0;
            cpl_data  <= rx_cls.cfg_rd ? rd_data : '0;
        end
    end
endmodule

// File: rtl/poison_status_checker.sv
// Module: property checker for poison_status_tracker, attached by bind.
// Assumes: signals sampled at the rising clock edge; reset is synchronous.
module poison_status_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic [31:0] rx_hdr0,
    input logic        tx_valid,
    input logic [31:0] tx_hdr0,
    input logic        app_valid,
    input logic        app_poisoned,
    input logic        link_valid,
    input logic [31:0] link_hdr0,
    input logic        cpl_valid,
    input logic [31:0] cpl_hdr0,
    input logic        detected_perr,
    input logic        master_perr,
    input logic [15:0] cmd_q
);
    // R2
    rx_poison_sets_dpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_hdr0[14]) |=> detected_perr);

    // R3
    tx_write_sets_mdpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[6] && tx_valid && tx_hdr0[14] &&
         (tx_hdr0[31:24] == 8'h40 || tx_hdr0[31:24] == 8'h60)) |=> master_perr);

    // R4
    rx_cpld_sets_mdpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[6] && rx_valid && rx_hdr0[14] && rx_hdr0[31:24] == 8'h4A) |=> master_perr);

    // R5
    mdpe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_q[6] && !master_perr) |=> !master_perr);

    // R8
    poisoned_cfgwr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_hdr0[14] && rx_hdr0[31:24] == 8'h44) |=> $stable(cmd_q));

    // R9
    app_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (app_valid && app_poisoned == $past(rx_hdr0[14])));

    // R10
    link_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> (link_valid && link_hdr0 == $past(tx_hdr0)));

    // R11
    clean_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (!cpl_hdr0[14] && $past(rx_valid) && $past(rx_hdr0[31:24]) == 8'h04));
endmodule

bind poison_status_tracker poison_status_checker i_poison_status_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_hdr0       (rx_hdr0),
    .tx_valid      (tx_valid),
    .tx_hdr0       (tx_hdr0),
    .app_valid     (app_valid),
    .app_poisoned  (app_poisoned),
    .link_valid    (link_valid),
    .link_hdr0     (link_hdr0),
    .cpl_valid     (cpl_valid),
    .cpl_hdr0      (cpl_hdr0),
    .detected_perr (detected_perr),
    .master_perr   (master_perr),
    .cmd_q         (cmd_q)
);

// File: tb/test_poison_status_tracker.sv
// Bench: scoreboard for completions (driver pushes, monitor pops), direct
// checks for status bits and forwarding.
module test_poison_status_tracker;
    localparam int NREGS = 4;
    localparam int IDX_W = $clog2(NREGS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_valid = 1'b0;
    logic [31:0]      rx_hdr0 = '0;
    logic [IDX_W-1:0] rx_cfg_idx = '0;
    logic [31:0]      rx_data = '0;
    logic             tx_valid = 1'b0;
    logic [31:0]      tx_hdr0 = '0;
    logic             app_valid, app_poisoned, link_valid, cpl_valid;
    logic [31:0]      app_hdr0, app_data, link_hdr0, cpl_hdr0, cpl_data;
    logic             detected_perr, master_perr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;

    poison_status_tracker #(.NREGS(NREGS)) i_poison_status_tracker (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_hdr0(rx_hdr0), .rx_cfg_idx(rx_cfg_idx), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_hdr0(tx_hdr0),
        .app_valid(app_valid), .app_hdr0(app_hdr0), .app_data(app_data), .app_poisoned(app_poisoned),
        .link_valid(link_valid), .link_hdr0(link_hdr0),
        .cpl_valid(cpl_valid), .cpl_hdr0(cpl_hdr0), .cpl_data(cpl_data),
        .detected_perr(detected_perr), .master_perr(master_perr)
    );

    function automatic logic [31:0] mk(input logic [7:0] ft, input logic ep);
        return {ft, 8'h00, 1'b0, ep, 14'd1};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; returns at the negedge where results are visible
    task automatic drive(input logic rv, input logic [31:0] rh, input logic [IDX_W-1:0] ri,
                         input logic [31:0] rd, input logic tv, input logic [31:0] th);
        @(negedge clk);
        rx_valid = rv; rx_hdr0 = rh; rx_cfg_idx = ri; rx_data = rd;
        tx_valid = tv; tx_hdr0 = th;
        @(negedge clk);
        rx_valid = 1'b0; rx_hdr0 = '0; rx_cfg_idx = '0; rx_data = '0;
        tx_valid = 1'b0; tx_hdr0 = '0;
    endtask

    task automatic cfg_write(input logic [IDX_W-1:0] idx, input logic [31:0] d, input logic ep);
        drive(1'b1, mk(8'h44, ep), idx, d, 1'b0, '0);
    endtask

    // R11: expected completion payload goes to the scoreboard
    task automatic cfg_read(input logic [IDX_W-1:0] idx, input logic [31:0] exp);
        exp_q.push_back(exp);
        drive(1'b1, mk(8'h04, 1'b0), idx, '0, 1'b0, '0);
    endtask

    task automatic stat(input string req, input logic dpe, input logic mdpe);
        chk({req, " dpe"}, {31'b0, detected_perr}, {31'b0, dpe});
        chk({req, " mdpe"}, {31'b0, master_perr}, {31'b0, mdpe});
    endtask

    // monitor: pop and compare every completion (R11)
    always @(negedge clk) begin
        if (rst_n && cpl_valid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected completion", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk("R11 cpl header", cpl_hdr0, 32'h4A00_0001);
                chk("R11 cpl data", cpl_data, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        stat("R1", 1'b0, 1'b0);
        chk("R1 app_valid", {31'b0, app_valid}, 32'h0);
        chk("R1 link_valid", {31'b0, link_valid}, 32'h0);
        chk("R1 cpl_valid", {31'b0, cpl_valid}, 32'h0);
        cfg_read(0, 32'h0);
        cfg_read(2, 32'h0);

        // R2 R5 R9: poisoned receive write, reporting disabled
        drive(1'b1, mk(8'h40, 1'b1), 0, 32'hCAFE_0001, 1'b0, '0);
        stat("R2 R5", 1'b1, 1'b0);
        chk("R9 app_valid", {31'b0, app_valid}, 32'h1);
        chk("R9 app_hdr0", app_hdr0, mk(8'h40, 1'b1));
        chk("R9 app_data", app_data, 32'hCAFE_0001);
        chk("R9 app_poisoned", {31'b0, app_poisoned}, 32'h1);

        // R5 R10: poisoned transmit write while disabled; still forwarded
        drive(1'b0, '0, 0, '0, 1'b1, mk(8'h60, 1'b1));
        stat("R5 R10", 1'b1, 1'b0);
        chk("R10 link_valid", {31'b0, link_valid}, 32'h1);
        chk("R10 link_hdr0", link_hdr0, mk(8'h60, 1'b1));

        // R6: write 0 in bit 31 keeps, then 1 clears
        cfg_write(0, 32'h0000_0000, 1'b0);
        stat("R6 keep", 1'b1, 1'b0);
        cfg_write(0, 32'h8000_0000, 1'b0);
        stat("R6 clear dpe", 1'b0, 1'b0);

        // enable reporting, read back word 0
        cfg_write(0, 32'h0000_0040, 1'b0);
        cfg_read(0, 32'h0000_0040);

        // R3: poisoned 64-bit address write transmitted
        drive(1'b0, '0, 0, '0, 1'b1, mk(8'h60, 1'b1));
        stat("R3", 1'b0, 1'b1);
        cfg_read(0, 32'h0100_0040);
        // R6: clear master bit
        cfg_write(0, 32'h0100_0040, 1'b0);
        stat("R6 clear mdpe", 1'b0, 1'b0);
        // R3: 32-bit address variant; clean write does nothing
        drive(1'b0, '0, 0, '0, 1'b1, mk(8'h40, 1'b0));
        stat("R3 clean", 1'b0, 1'b0);
        drive(1'b0, '0, 0, '0, 1'b1, mk(8'h40, 1'b1));
        stat("R3 mwr32", 1'b0, 1'b1);
        cfg_write(0, 32'h0100_0040, 1'b0);

        // R4: poisoned completion received
        drive(1'b1, mk(8'h4A, 1'b1), 0, 32'h1, 1'b0, '0);
        stat("R4", 1'b1, 1'b1);
        cfg_write(0, 32'h8100_0040, 1'b0);
        stat("R6 clear both", 1'b0, 1'b0);

        // R8: corrupted config writes change nothing by their data
        cfg_write(1, 32'h0000_1234, 1'b0);
        cfg_write(1, 32'hDEAD_BEEF, 1'b1);
        stat("R8 status still set", 1'b1, 1'b0);
        cfg_read(1, 32'h0000_1234);
        cfg_write(0, 32'h8000_0000, 1'b1);
        stat("R8 no clear", 1'b1, 1'b0);
        cfg_read(0, 32'h8000_0040);
        // enable still on: proves the command survived
        drive(1'b0, '0, 0, '0, 1'b1, mk(8'h40, 1'b1));
        stat("R8 enable kept", 1'b1, 1'b1);

        // R7: set and clear of master bit in the same cycle
        drive(1'b1, mk(8'h44, 1'b0), 0, 32'h8100_0040, 1'b1, mk(8'h60, 1'b1));
        stat("R7", 1'b0, 1'b1);
        cfg_write(0, 32'h8100_0040, 1'b0);

        // R12: both directions in one cycle
        drive(1'b1, mk(8'h40, 1'b1), 0, 32'h55, 1'b1, mk(8'h40, 1'b1));
        stat("R12", 1'b1, 1'b1);
        chk("R12 app_valid", {31'b0, app_valid}, 32'h1);
        chk("R12 link_valid", {31'b0, link_valid}, 32'h1);

        // R5: disable and clear, then poisoned completion must not set master bit
        cfg_write(0, 32'h8100_0000, 1'b0);
        stat("R5 cleared", 1'b0, 1'b0);
        drive(1'b1, mk(8'h4A, 1'b1), 0, '0, 1'b1, mk(8'h60, 1'b1));
        stat("R5 disabled", 1'b1, 1'b0);

        repeat (2) @(negedge clk);
        chk("R11 scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule